// File: doc/BRIEF.md
# Multi-Line Receive Silo with Interrupt Timeout

This block is the shared receive queue of a sixteen-line serial multiplexer. Every per-line receiver offers finished entries to it. An entry is either a received character with its error flags, or a record that reports a change of modem status. The host reads the entry at the head of the queue from a read port. It removes that entry with a one-cycle pop strobe, and it keeps going until the valid bit of the read word is clear.

A receive interrupt is raised under one of three policies, chosen by an 8-bit delay value:
- **Delay 0 (poll only):** interrupt only on status records or on the fill alarm.
- **Delay 1:** interrupt as soon as anything is queued.
- **Delay 2 to 255:** interrupt that many millisecond ticks after the queue last went from empty to non-empty.

The fill alarm at three-quarters full and stored status records raise the interrupt under every policy.

A master-clear strobe does the following:
- It flushes the queue and runs a short self-test sequence.
- It loads eight diagnostic records, one per cycle, while the clear-busy output is high.
- It records the externally supplied self-test result as a sticky fail flag.

Top module: `rx_silo`

## Requirements
- R1: The read word is {valid[15], status[14:12], line[11:8], data[7:0]} for the head entry. It is all zero while the queue is empty.
- R2: A pop strobe removes the head entry, and entries leave in arrival order. A pop while empty changes nothing.
- R3: On a data entry, status bit 12 flags a parity error and bit 13 flags a framing error. The parity flag is forced clear whenever the framing flag is set, so a data entry never has status 3'b111.
- R4: A modem-status record has status 3'b111 and the source line number. Its data bit 7 is 0 and its bits 6:0 are taken from the receiver's data bits 6:0.
- R5: The queue holds 256 entries. A push offered when it is full is dropped. The next data entry stored after a drop carries status bit 14 (overrun), and the data entry after that does not.
- R6: With delay 0, queued data alone does not interrupt while fewer than 192 entries are held. Holding 192 or more entries raises the interrupt.
- R7: With delay 1, the interrupt is high from the cycle after the first entry is stored.
- R8: With delay N (2 to 255), the interrupt rises once N millisecond ticks have been counted since the queue last went from empty to non-empty. Pushes into a queue that is already non-empty do not restart the count.
- R9: Storing a status or diagnostic record raises the interrupt under any delay value. It stays raised until the queue empties.
- R10: The interrupt is a level: it is low whenever the queue is empty or the enable input is low.
- R11: A master clear flushes the queue and holds clear-busy high for exactly 8 cycles. Receiver pushes are ignored during that time. It then leaves 8 diagnostic records {status 3'b111, line 0, data 0x80 | fail<<3 | k} for k = 0..7, in that order.
- R12: The diagnostic-fail output equals the self-test result input sampled with the master clear. It holds until the next master clear, and the fail bit (data bit 3) of the diagnostic records matches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ln_valid | input | 1 | Receiver offers an entry this cycle |
| ln_line | input | 4 | Source line number |
| ln_kind | input | 1 | 0 = character, 1 = modem-status record |
| ln_data | input | 8 | Character or modem status bits |
| ln_perr | input | 1 | Parity error on the character |
| ln_ferr | input | 1 | Framing error on the character |
| pop | input | 1 | Remove the head entry |
| rd_entry | output | 16 | Head entry with valid bit |
| tmo_val | input | 8 | Interrupt delay policy value |
| ie | input | 1 | Interrupt enable |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| mclr | input | 1 | Master-clear strobe |
| self_fail | input | 1 | Self-test result, 1 = failed |
| mclr_busy | output | 1 | Master clear in progress |
| diag_fail | output | 1 | Sticky self-test failure |
| irq | output | 1 | Receive interrupt (level) |

## Verification
The bench checks the delay count across a second push into an already non-empty queue. A timer that restarts on every character would hold the interrupt back one extra tick. It also checks the alarm at exactly 191 and 192 entries, and the overrun mark on the first and second data entries after a dropped push. An off-by-one threshold, or an overrun flag that is sticky or lost, shows up there. A character with both parity and framing errors must not read back as a status record. The master-clear checks count the busy cycles, confirm that pushes during the clear are lost, and read back all eight diagnostic codes with the fail bit in both states.

// File: rtl/rx_silo.sv
module rx_silo #(
  parameter int DEPTH  = 256,
  parameter int LINE_W = 4,
  parameter int DATA_W = 8,
  parameter int TMO_W  = 8,
  parameter int NDIAG  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ln_valid,
  input  logic [LINE_W-1:0]         ln_line,
  input  logic                      ln_kind,
  input  logic [DATA_W-1:0]         ln_data,
  input  logic                      ln_perr,
  input  logic                      ln_ferr,
  input  logic                      pop,
  output logic [LINE_W+DATA_W+3:0]  rd_entry,
  input  logic [TMO_W-1:0]          tmo_val,
  input  logic                      ie,
  input  logic                      ms_tick,
  input  logic                      mclr,
  input  logic                      self_fail,
  output logic                      mclr_busy,
  output logic                      diag_fail,
  output logic                      irq
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int EW    = 3 + LINE_W + DATA_W;
  localparam int ALARM = (3 * DEPTH) / 4;
  localparam int DW    = $clog2(NDIAG);

  logic [EW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, count_nx;
  logic [TMO_W-1:0] tcnt;
  logic [DW-1:0]    dstep;
  logic             ovr_pend, rec_pend, busy, fail_r;

  wire empty    = (count == '0);
  wire full     = (count == CW'(DEPTH));
  wire accept   = ln_valid & ~busy & ~mclr;
  wire ln_store = accept & ~full;
  wire drop     = accept & full;
  wire wr_en    = (busy & ~mclr) | ln_store;
  wire pop_en   = pop & ~empty & ~busy & ~mclr;
  wire wr_rec   = busy | ln_kind;

  wire [2:0]        ln_flags = ln_kind ? 3'b111 : {ovr_pend, ln_ferr, ln_perr & ~ln_ferr};
  wire [DATA_W-1:0] ln_body  = ln_kind ? {1'b0, ln_data[DATA_W-2:0]} : ln_data;
  wire [DATA_W-1:0] dcode    = {1'b1, {(DATA_W-DW-2){1'b0}}, fail_r, dstep};
  wire [EW-1:0]     wr_word  = busy ? {3'b111, {LINE_W{1'b0}}, dcode}
                                    : {ln_flags, ln_line, ln_body};

  wire expired = (tmo_val >= TMO_W'(2)) && (tcnt >= tmo_val);
  wire alarm   = (count >= CW'(ALARM));
  wire imm     = (tmo_val == TMO_W'(1));

  assign count_nx  = count + CW'(wr_en) - CW'(pop_en);
  assign rd_entry  = empty ? '0 : {1'b1, mem[rd_ptr]};
  assign mclr_busy = busy;
  assign diag_fail = fail_r;
  assign irq       = ie & ~empty & (rec_pend | alarm | imm | expired);

  always_ff @(posedge clk)
    if (wr_en) mem[wr_ptr] <= wr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; tcnt <= '0; dstep <= '0;
      ovr_pend <= 1'b0; rec_pend <= 1'b0; busy <= 1'b0; fail_r <= 1'b0;
    end else if (mclr) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; tcnt <= '0; dstep <= '0;
      ovr_pend <= 1'b0; rec_pend <= 1'b0; busy <= 1'b1; fail_r <= self_fail;
    end else begin
      if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
      if (pop_en) rd_ptr <= rd_ptr + 1'b1;
      count <= count_nx;
      if (drop) ovr_pend <= 1'b1;
      else if (ln_store && !ln_kind) ovr_pend <= 1'b0;
      if (wr_en && wr_rec) rec_pend <= 1'b1;
      else if (count_nx == '0) rec_pend <= 1'b0;
      if (empty && wr_en) tcnt <= '0;
      else if (ms_tick && !empty && tcnt != '1) tcnt <= tcnt + 1'b1;
      if (busy) begin
        dstep <= dstep + 1'b1;
        if (dstep == DW'(NDIAG - 1)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
  parameter int EWV   = 16,
  parameter int TMO_W = 8,
  parameter int CW    = 9,
  parameter int DEPTH = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic [EWV-1:0] rd_entry,
  input logic           irq,
  input logic           ie,
  input logic [TMO_W-1:0] tmo_val,
  input logic           ln_valid,
  input logic           mclr,
  input logic           mclr_busy,
  input logic [CW-1:0]  count
);
  p_irq_needs_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_entry[EWV-1] |-> !irq);
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);
  p_immediate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && tmo_val == TMO_W'(1) && rd_entry[EWV-1]) |-> irq);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_pop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_entry[EWV-1] && !ln_valid && !mclr && !mclr_busy) |=> !rd_entry[EWV-1]);
  p_diag_loaded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclr_busy) |-> rd_entry[EWV-1]);
endmodule

bind rx_silo rx_silo_chk #(.EWV(LINE_W+DATA_W+4), .TMO_W(TMO_W), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_entry(rd_entry), .irq(irq), .ie(ie),
  .tmo_val(tmo_val), .ln_valid(ln_valid), .mclr(mclr), .mclr_busy(mclr_busy),
  .count(count));

// File: tb/sim_rx_silo.sv
module sim_rx_silo;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ln_valid = 0, ln_kind = 0, ln_perr = 0, ln_ferr = 0, pop = 0;
  logic [3:0] ln_line = 0;
  logic [7:0] ln_data = 0, tmo_val = 0;
  logic ie = 0, ms_tick = 0, mclr = 0, self_fail = 0;
  logic [15:0] rd_entry;
  logic mclr_busy, diag_fail, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_silo u0 (.clk, .rst_n, .ln_valid, .ln_line, .ln_kind, .ln_data, .ln_perr,
    .ln_ferr, .pop, .rd_entry, .tmo_val, .ie, .ms_tick, .mclr, .self_fail,
    .mclr_busy, .diag_fail, .irq);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] l, input logic [7:0] d, input logic k,
                      input logic pe, input logic fe);
    ln_valid = 1; ln_line = l; ln_data = d; ln_kind = k; ln_perr = pe; ln_ferr = fe;
    @(negedge clk);
    ln_valid = 0; ln_kind = 0; ln_perr = 0; ln_ferr = 0;
  endtask

  task automatic pop1();
    pop = 1; @(negedge clk); pop = 0;
  endtask

  task automatic tick();
    ms_tick = 1; @(negedge clk); ms_tick = 0;
  endtask

  task automatic drain();
    while (rd_entry[15]) pop1();
  endtask

  task automatic t_reset();
    chk(rd_entry, 16'h0000, "R1 empty read word after reset");
    chk(irq, 0, "R10 irq after reset");
    chk(mclr_busy, 0, "R11 busy after reset");
    chk(diag_fail, 0, "R12 fail after reset");
  endtask

  task automatic t_data();
    tmo_val = 0; ie = 1;
    pop1();
    chk(rd_entry, 16'h0000, "R2 pop on empty");
    push(4'd5, 8'h41, 0, 0, 0);
    chk(rd_entry, 16'h8541, "R1 plain data entry");
    chk(irq, 0, "R6 poll mode data no irq");
    push(4'd3, 8'h7E, 0, 1, 0);
    push(4'd2, 8'h00, 0, 1, 1);
    chk(rd_entry, 16'h8541, "R2 head unchanged by pushes");
    pop1();
    chk(rd_entry, 16'h937E, "R3 parity flag");
    pop1();
    chk(rd_entry, 16'hA200, "R3 framing suppresses parity");
    pop1();
    chk(rd_entry, 16'h0000, "R2 drained");
  endtask

  task automatic t_modem();
    tmo_val = 0; ie = 1;
    push(4'd9, 8'hFF, 1, 0, 0);
    chk(rd_entry, 16'hF97F, "R4 modem record format");
    chk(irq, 1, "R9 record raises irq in poll mode");
    pop1();
    chk(irq, 0, "R10 irq drops when empty");
    push(4'd1, 8'h11, 0, 0, 0);
    chk(irq, 0, "R9 record pend cleared after empty");
    drain();
  endtask

  task automatic t_imm();
    tmo_val = 1; ie = 1;
    push(4'd4, 8'h22, 0, 0, 0);
    chk(irq, 1, "R7 immediate irq");
    ie = 0; #1;
    chk(irq, 0, "R10 masked by enable");
    ie = 1; #1;
    chk(irq, 1, "R10 level held");
    drain();
    chk(irq, 0, "R10 low when empty");
  endtask

  task automatic t_delay();
    tmo_val = 3; ie = 1;
    push(4'd6, 8'h01, 0, 0, 0);
    tick();
    push(4'd6, 8'h02, 0, 0, 0);
    tick();
    chk(irq, 0, "R8 no irq before delay");
    tick();
    chk(irq, 1, "R8 irq after delay, no restart on second push");
    drain();
    chk(irq, 0, "R8 irq clears on empty");
  endtask

  task automatic t_alarm();
    int n;
    tmo_val = 0; ie = 1;
    for (int i = 0; i < 191; i++) push(4'(i), 8'(i), 0, 0, 0);
    chk(irq, 0, "R6 below alarm");
    push(4'(191), 8'(191), 0, 0, 0);
    chk(irq, 1, "R6 alarm at 192");
    for (int i = 192; i < 258; i++) push(4'(i), 8'(i), 0, 0, 0);
    n = 0;
    while (rd_entry[15]) begin
      if (n == 0)   chk(rd_entry, 16'h8000, "R2 first entry of full silo");
      if (n == 255) chk(rd_entry, 16'h8FFF, "R5 last kept entry");
      n++;
      pop1();
    end
    chk(n, 256, "R5 depth 256 with drops");
    push(4'd1, 8'h55, 0, 0, 0);
    chk(rd_entry, 16'hC155, "R5 overrun flag on next entry");
    pop1();
    push(4'd1, 8'h56, 0, 0, 0);
    chk(rd_entry, 16'h8156, "R5 overrun flag once only");
    drain();
  endtask

  task automatic t_mclr(input logic f);
    int n;
    tmo_val = 0; ie = 1;
    push(4'd7, 8'h33, 0, 0, 0);
    self_fail = f; mclr = 1;
    @(negedge clk);
    mclr = 0; self_fail = 0;
    for (int i = 0; i < 8; i++) begin
      chk(mclr_busy, 1, "R11 busy during clear");
      if (i == 3) ln_valid = 1;
      if (i == 4) ln_valid = 0;
      @(negedge clk);
    end
    ln_valid = 0;
    chk(mclr_busy, 0, "R11 busy ends after 8 cycles");
    chk(diag_fail, 32'(f), "R12 fail flag");
    chk(irq, 1, "R9 diag records raise irq");
    n = 0;
    while (rd_entry[15]) begin
      chk(rd_entry, 32'(16'hF080 | (f ? 16'h0008 : 16'h0) | 16'(n)), "R11 diag code");
      n++;
      pop1();
    end
    chk(n, 8, "R11 eight codes, old data flushed");
    chk(diag_fail, 32'(f), "R12 fail flag held");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data();
    t_modem();
    t_imm();
    t_delay();
    t_alarm();
    t_mclr(1'b0);
    t_mclr(1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule